// File: doc/BRIEF.md
# Register-Memory Exchange Unit

This unit runs one small instruction family of a simple microcontroller core: it swaps one data register (A or B) with the data memory nibble that one index register (X or Y) points at. Three low opcode bits pick the data register, the index register and whether the index steps forward afterwards. The unit owns the four architectural registers it touches: A and B are 4 bits wide, and X and Y are 16 bits wide.

An extension prefix, latched elsewhere, can be pending when an exchange arrives. On a form without post-increment, the pending prefix replaces the address with an 8-bit offset inside a fixed page. X selects the bottom page and Y selects the top page. On post-increment forms the prefix has no effect. Either way the prefix is reported as consumed when the exchange finishes.

Instructions arrive on a valid/ready handshake. `instr_ready` is high only while the unit is idle. An instruction whose opcode is in the family is taken on a clock edge where `instr_valid` and `instr_ready` are both high. An instruction outside the family is never taken and starts nothing. A producer holding `instr_valid` high while the unit is busy simply waits. Memory is a synchronous port: read data appears in the cycle after the read strobe.

Top module: `xchg_unit`

## Requirements
- R1: An instruction is taken only if `opcode[12:3]` equals 10'b10_0001_1111, which covers opcodes 0x10F8 to 0x10FF. Any other opcode produces no memory strobe, no `done` and no change to any register.
- R2: `opcode[2]` selects the data register, with 0 for A and 1 for B. `opcode[1]` selects the index register, with 0 for X and 1 for Y.
- R3: In the first cycle after acceptance, `mem_rd_en` is high with the address. In the second cycle, `mem_wr_en` and `done` are high with the same address, and `mem_wdata` carries the old value of the data register. The data register takes `mem_rdata` at the end of that second cycle.
- R4: `instr_ready` is high exactly when no exchange is in progress. An instruction held valid during the two busy cycles is taken on the first idle edge.
- R5: When `opcode[0]` is 1, the selected index register increases by one at the end of the exchange, wrapping from 0xFFFF to 0x0000.
- R6: When `ext_active` is high at acceptance and `opcode[0]` is 0, the address is 0x0000 + `ext_imm` for X or 0xFF00 + `ext_imm` for Y. Both index registers stay unchanged.
- R7: When `opcode[0]` is 1, `ext_active` is ignored and the plain index value is the address.
- R8: `ext_consume` pulses in the completion cycle of every exchange, whether or not the prefix was used.
- R9: After reset, A = B = 0, X = `X_INIT` and Y = `Y_INIT`, `instr_ready` is high, and all strobes are low.
- R10: The data register and index register that the opcode does not select keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit idle, can take an instruction |
| opcode | input | 13 | Instruction word |
| ext_active | input | 1 | Extension prefix pending |
| ext_imm | input | 8 | Prefix page offset |
| ext_consume | output | 1 | Prefix consumed (pulse) |
| mem_addr | output | 16 | Data memory address |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rdata | input | 4 | Read data, one cycle after strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | 4 | Write data |
| done | output | 1 | Exchange completes this cycle |
| reg_a | output | 4 | Data register A |
| reg_b | output | 4 | Data register B |
| idx_x | output | 16 | Index register X |
| idx_y | output | 16 | Index register Y |

## Verification
The hardest case to reach from the ports is the index wrap from 0xFFFF to 0x0000. Walking an index there one increment at a time would take tens of thousands of exchanges. The bench instead builds the unit with `Y_INIT` set to 0xFFFE, so two post-increment exchanges through Y cross the wrap. The bench also holds `instr_valid` high across the busy cycles to exercise the back-pressure rule. It offers a prefix together with a post-increment form to confirm the prefix is ignored there.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  localparam int unsigned OPC_W    = 13;
  localparam int unsigned PAGE_W   = 8;
  localparam logic [9:0]  FAMILY   = 10'b10_0001_1111;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} xchg_state_e;

  typedef struct packed {
    logic              sel_b;
    logic              sel_y;
    logic              post_inc;
    logic              use_page;
    logic [PAGE_W-1:0] imm;
  } xchg_cmd_t;

  function automatic logic in_family(input logic [OPC_W-1:0] op);
    return op[OPC_W-1:3] == FAMILY;
  endfunction
endpackage

// File: rtl/xchg_decode.sv
module xchg_decode
  import xchg_pkg::*;
(
  input  logic [OPC_W-1:0]  opcode,
  input  logic              ext_active,
  input  logic [PAGE_W-1:0] ext_imm,
  output logic              hit,
  output xchg_cmd_t         cmd
);
  always_comb begin
    hit          = in_family(opcode);
    cmd.sel_b    = opcode[2];
    cmd.sel_y    = opcode[1];
    cmd.post_inc = opcode[0];
    // page addressing is only legal on the plain forms
    cmd.use_page = ext_active && !opcode[0];
    cmd.imm      = ext_imm;
  end
endmodule

// File: rtl/xchg_ctrl.sv
module xchg_ctrl
  import xchg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      instr_valid,
  input  logic      hit,
  input  xchg_cmd_t cmd_in,
  output logic      instr_ready,
  output xchg_cmd_t cmd_q,
  output logic      rd_phase,
  output logic      wr_phase
);
  xchg_state_e state_q;
  logic        accept;

  assign instr_ready = (state_q == ST_IDLE);
  assign accept      = instr_valid && instr_ready && hit;
  assign rd_phase    = (state_q == ST_READ);
  assign wr_phase    = (state_q == ST_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (accept) begin
                    state_q <= ST_READ;
                    cmd_q   <= cmd_in;
                  end
        ST_READ:  state_q <= ST_WRITE;
        ST_WRITE: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xchg_regs.sv
module xchg_regs #(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] X_INIT = '0,
  parameter logic [ADDR_W-1:0] Y_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              sel_b,
  input  logic              sel_y,
  input  logic              post_inc,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] data_sel,
  output logic [ADDR_W-1:0] idx_sel,
  output logic [DATA_W-1:0] data_a,
  output logic [DATA_W-1:0] data_b,
  output logic [ADDR_W-1:0] index_x,
  output logic [ADDR_W-1:0] index_y
);
  localparam int unsigned NREG = 2;

  logic [DATA_W-1:0] data_q [NREG];
  logic [ADDR_W-1:0] idx_q  [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] RST_IDX = (g == 0) ? X_INIT : Y_INIT;

    always_ff @(posedge clk) begin
      if (!rst_n)
        data_q[g] <= '0;
      else if (commit && (sel_b == 1'(g)))
        data_q[g] <= load_data;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        idx_q[g] <= RST_IDX;
      else if (commit && post_inc && (sel_y == 1'(g)))
        idx_q[g] <= idx_q[g] + 1'b1;
    end
  end

  assign data_sel = data_q[sel_b];
  assign idx_sel  = idx_q[sel_y];
  assign data_a   = data_q[0];
  assign data_b   = data_q[1];
  assign index_x  = idx_q[0];
  assign index_y  = idx_q[1];
endmodule

// File: rtl/xchg_unit.sv
module xchg_unit
  import xchg_pkg::*;
#(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] X_INIT = '0,
  parameter logic [ADDR_W-1:0] Y_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              ext_active,
  input  logic [PAGE_W-1:0] ext_imm,
  output logic              ext_consume,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              done,
  output logic [DATA_W-1:0] reg_a,
  output logic [DATA_W-1:0] reg_b,
  output logic [ADDR_W-1:0] idx_x,
  output logic [ADDR_W-1:0] idx_y
);
  localparam int unsigned HI_W = ADDR_W - PAGE_W;

  xchg_cmd_t         cmd_dec, cmd_q;
  logic              hit, rd_phase, wr_phase;
  logic [DATA_W-1:0] data_sel;
  logic [ADDR_W-1:0] idx_sel;

  xchg_decode u_dec (
    .opcode     (opcode),
    .ext_active (ext_active),
    .ext_imm    (ext_imm),
    .hit        (hit),
    .cmd        (cmd_dec)
  );

  xchg_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .hit         (hit),
    .cmd_in      (cmd_dec),
    .instr_ready (instr_ready),
    .cmd_q       (cmd_q),
    .rd_phase    (rd_phase),
    .wr_phase    (wr_phase)
  );

  xchg_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .X_INIT (X_INIT),
    .Y_INIT (Y_INIT)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (wr_phase),
    .sel_b     (cmd_q.sel_b),
    .sel_y     (cmd_q.sel_y),
    .post_inc  (cmd_q.post_inc),
    .load_data (mem_rdata),
    .data_sel  (data_sel),
    .idx_sel   (idx_sel),
    .data_a    (reg_a),
    .data_b    (reg_b),
    .index_x   (idx_x),
    .index_y   (idx_y)
  );

  // bottom page for X (upper bits 0), top page for Y (upper bits 1)
  assign mem_addr    = cmd_q.use_page ? {{HI_W{cmd_q.sel_y}}, cmd_q.imm} : idx_sel;
  assign mem_rd_en   = rd_phase;
  assign mem_wr_en   = wr_phase;
  assign mem_wdata   = data_sel;
  assign done        = wr_phase;
  assign ext_consume = wr_phase;
endmodule

// File: rtl/xchg_chk.sv
module xchg_chk
  import xchg_pkg::*;
#(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic              instr_ready,
  input logic [OPC_W-1:0]  opcode,
  input logic              ext_consume,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic              done,
  input logic [DATA_W-1:0] reg_a,
  input logic [DATA_W-1:0] reg_b,
  input logic [ADDR_W-1:0] idx_x,
  input logic [ADDR_W-1:0] idx_y
);
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> mem_wr_en); // R3
  AST_WRITE_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> mem_addr == $past(mem_addr)); // R3
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en)); // R3
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(reg_a) && $stable(reg_b) && $stable(idx_x) && $stable(idx_y))); // R3
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> !instr_ready); // R4
  AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready && !in_family(opcode)) |=> !mem_rd_en); // R1
  AST_CONSUME_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ext_consume); // R8
endmodule

bind xchg_unit xchg_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
  .opcode(opcode), .ext_consume(ext_consume), .mem_addr(mem_addr),
  .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .done(done),
  .reg_a(reg_a), .reg_b(reg_b), .idx_x(idx_x), .idx_y(idx_y)
);

// File: tb/sim_xchg_unit.sv
`timescale 1ns/1ps
module sim_xchg_unit;
  localparam logic [15:0] XI = 16'h0010;
  localparam logic [15:0] YI = 16'hFFFE;

  logic clk = 0, rst_n = 0;
  logic instr_valid = 0, ext_active = 0;
  logic [12:0] opcode = '0;
  logic [7:0]  ext_imm = '0;
  logic [3:0]  mem_rdata = '0;
  logic instr_ready, ext_consume, mem_rd_en, mem_wr_en, done;
  logic [15:0] mem_addr, idx_x, idx_y;
  logic [3:0]  mem_wdata, reg_a, reg_b;

  always #4 clk = ~clk;

  xchg_unit #(.X_INIT(XI), .Y_INIT(YI)) u0 (.*);

  int n_run = 0, n_fail = 0, cyc = 0;

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory serving the DUT
  logic [3:0] tb_mem [int];
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= tb_mem.exists(int'(mem_addr)) ? tb_mem[int'(mem_addr)] : 4'h0;
    if (mem_wr_en) tb_mem[int'(mem_addr)] = mem_wdata;
  end

  // behavioural reference
  int m_mem [int];
  int m_a, m_b, m_x, m_y, m_phase, m_addr;
  int m_selb, m_sely, m_inc, m_ext;

  function automatic int mrd(int a);
    return m_mem.exists(a) ? m_mem[a] : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_x = XI; m_y = YI; m_phase = 0;
    end else begin
      case (m_phase)
        0: if (instr_valid && (opcode >> 3) == 13'h21F) begin
             m_selb = opcode[2]; m_sely = opcode[1]; m_inc = opcode[0];
             m_ext  = ext_active && !opcode[0];
             if (m_ext) m_addr = (m_sely ? 16'hFF00 : 0) + ext_imm;
             else       m_addr = m_sely ? m_y : m_x;
             m_phase = 1;
           end
        1: m_phase = 2;
        default: begin
          int old;
          old = mrd(m_addr);
          m_mem[m_addr] = m_selb ? m_b : m_a;
          if (m_selb) m_b = old; else m_a = old;
          if (m_inc) begin
            if (m_sely) m_y = (m_y + 1) & 16'hFFFF;
            else        m_x = (m_x + 1) & 16'hFFFF;
          end
          m_phase = 0;
        end
      endcase
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) if (rst_n) begin
    cyc++;
    chk("R4 instr_ready", instr_ready, m_phase == 0);
    chk("R1/R3 mem_rd_en", mem_rd_en, m_phase == 1);
    chk("R3 mem_wr_en", mem_wr_en, m_phase == 2);
    chk("R3 done", done, m_phase == 2);
    chk("R8 ext_consume", ext_consume, m_phase == 2);
    if (m_phase != 0)
      chk(m_ext ? "R6 mem_addr" : (m_inc ? "R7 mem_addr" : "R2 mem_addr"), mem_addr, m_addr);
    if (m_phase == 2) chk("R3 mem_wdata", mem_wdata, m_selb ? m_b : m_a);
    chk("R10 reg_a", reg_a, m_a);
    chk("R10 reg_b", reg_b, m_b);
    chk("R5 idx_x", idx_x, m_x);
    chk("R5 idx_y", idx_y, m_y);
  end

  task automatic put(int a, int v);
    tb_mem[a] = 4'(v); m_mem[a] = v;
  endtask

  task automatic issue(logic [12:0] op, bit ext, logic [7:0] imm, bit keep);
    @(negedge clk);
    instr_valid = 1; opcode = op; ext_active = ext; ext_imm = imm;
    while (!instr_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    if (!keep) begin instr_valid = 0; ext_active = 0; end
  endtask

  task automatic settle(); repeat (3) @(negedge clk); endtask

  initial begin
    put('h0010, 5); put('hFFFE, 'hA); put('hFFFF, 'h3); put('h0034, 'h7);
    put('hFF56, 'h9); put('h0000, 'hC); put('h0011, 'h2);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reg_a", reg_a, 0); chk("R9 reg_b", reg_b, 0);
    chk("R9 idx_x", idx_x, XI); chk("R9 idx_y", idx_y, YI);
    chk("R9 ready", instr_ready, 1);
    chk("R9 strobes", {mem_rd_en, mem_wr_en, done}, 0);
    rst_n = 1;

    issue(13'h10F8, 0, 0, 0); settle();          // A <-> [X]
    chk("R2 A loaded", reg_a, 5);
    issue(13'h10FF, 0, 0, 0); settle();          // B <-> [Y]+ , Y=FFFF
    chk("R5 Y step", idx_y, 16'hFFFF);
    issue(13'h10FB, 0, 0, 0); settle();          // A <-> [Y]+ , Y wraps
    chk("R5 Y wrap", idx_y, 16'h0000);
    chk("R10 B held", reg_b, 4'hA);

    issue(13'h10F0, 0, 0, 0); settle();          // R1 foreign opcodes
    issue(13'h1FF8, 0, 0, 0); settle();
    issue(13'h0000, 1, 8'h12, 0); settle();
    chk("R1 nothing changed", reg_a, m_a);

    issue(13'h10FC, 1, 8'h34, 0); settle();      // R6 B <-> [0x0034]
    chk("R6 B from page0", reg_b, 7);
    chk("R6 X unchanged", idx_x, XI);
    issue(13'h10FA, 1, 8'h56, 0); settle();      // R6 A <-> [0xFF56]
    chk("R6 A from top page", reg_a, 9);
    issue(13'h10F9, 1, 8'h34, 0); settle();      // R7 prefix ignored
    chk("R7 X incremented", idx_x, XI + 1);

    issue(13'h10FD, 0, 0, 1);                    // R4 back-to-back
    issue(13'h10F9, 0, 0, 0); settle();

    for (int k = 0; k < 8; k++) begin
      issue(13'h10F8 + 13'(k), k[2], 8'(k * 17), 0);
      settle();
    end

    foreach (m_mem[a])
      chk("R3 memory image", tb_mem.exists(a) ? int'(tb_mem[a]) : 0, m_mem[a]);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule